// File: doc/BRIEF.md
# Three-Phase Inverter Switching Model

This block is a fixed-point, cycle-based model of a two-level three-phase voltage-source inverter, meant for real-time plant simulation on an FPGA. Each valid sample carries a DC-link voltage, three machine phase currents, three back-EMF voltages, a 6-bit gate word, a global pulse-disable bit and a CPU sync strobe. For each sample the block produces three phase voltages, a per-phase high-impedance flag word for the downstream machine model and a shoot-through error bit. The sample passes through a fixed-latency pipeline whose depth depends on whether the conduction offset and on-resistance parameters are in use.

Each leg is evaluated on its own from its two gate bits and the sign of its current. Driven legs give the DC-link or ground potential, adjusted by the forward offset and the resistive drop. Undriven legs freewheel through the diode that the current direction selects. When an undriven leg carries exactly zero current it floats: it follows the back-EMF and is flagged as high-impedance. An optional stage sums the DC-link current over each sync period.

All voltages and currents are signed 18-bit values with 15 fractional bits, in per-unit. `VF_PU` and `RON_PU` use the same format.

Top module: `inv3ph_model`

## Requirements
- R1: Gate bit 5 drives the phase A top switch and bit 4 the phase A bottom switch. Bits 3/2 do the same for phase B and bits 1/0 for phase C. With only the top switch on, the phase voltage is Vdc − Vf − round(Ron·I). Round(x·y) is the product shifted right by 15 after adding 2^14.
- R2: With only the bottom switch on, the phase voltage is Vf − round(Ron·I).
- R3: With both switches of a leg on, that leg takes the bottom-on voltage and `shoot_err` is 1 for that sample. It is 0 when no leg has both switches on.
- R4: With both switches off, a positive current gives −Vf and a negative current gives Vdc + Vf.
- R5: With both switches off and a current of exactly zero, the phase voltage equals that phase's back-EMF and its `hiz` bit is 1 (bit 2 = A, bit 1 = B, bit 0 = C). In every other case the `hiz` bit is 0.
- R6: While `pulse_off` is 1, all six switches are treated as off whatever `gates` holds.
- R7: Every phase voltage saturates to the range −131072 … 131071.
- R8: A sample accepted with `in_valid` appears with `out_valid` after exactly LAT clock edges. LAT = 8 + 5·[RON_PU≠0] + 5·[VF_PU≠0], which gives 18 when both are non-zero.
- R9: While `out_valid` is 0, the outputs `va`, `vb`, `vc`, `hiz` and `shoot_err` hold their last values. After reset they are all 0.
- R10: When DCLINK_EN is 1, each valid sample adds a DC-link current term to a saturating accumulator. The term is the sum of the currents of the legs whose top path conducts (top switch alone on, or both off with negative current). A `sync` pulse copies the accumulator to `idc_sum` and restarts the sum. `idc_sum` changes only on `sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| vdc | input | 18 | DC-link voltage, signed Q2.15 pu |
| ia | input | 18 | Phase A current |
| ib | input | 18 | Phase B current |
| ic | input | 18 | Phase C current |
| bemf_a | input | 18 | Phase A back-EMF |
| bemf_b | input | 18 | Phase B back-EMF |
| bemf_c | input | 18 | Phase C back-EMF |
| gates | input | 6 | Gate word, {A top, A bot, B top, B bot, C top, C bot} |
| pulse_off | input | 1 | Forces all switches off |
| sync | input | 1 | Latches and restarts the DC-link current sum |
| out_valid | output | 1 | Output sample strobe |
| va | output | 18 | Phase A voltage |
| vb | output | 18 | Phase B voltage |
| vc | output | 18 | Phase C voltage |
| hiz | output | 3 | Floating-phase flags {A, B, C} |
| shoot_err | output | 1 | Some leg had both switches on |
| idc_sum | output | ACC_W | Accumulated DC-link current of the last sync period |

## Verification
The bench applies a zero current to an undriven leg to catch a design that sends it through a diode instead of floating it on the back-EMF. It also drives both switches of a leg at once, which a design with the wrong priority would resolve to Vdc, and asserts `pulse_off` over an all-ones gate word, which exposes a mask that is missing or inverted. Extreme DC-link values reveal arithmetic that wraps instead of saturating. The output is timed edge by edge to catch a pipeline that is one stage short or long, and after the output the bench waits to see that the values hold. The DC-link sum mixes top-on, top-diode and shoot-through legs, so that counting a wrong leg or clearing on the wrong edge gives a wrong total.

// File: rtl/inv3ph_model.sv
module inv3ph_model #(
  parameter int W         = 18,
  parameter int FRAC      = 15,
  parameter int VF_PU     = 1638,
  parameter int RON_PU    = 3277,
  parameter bit DCLINK_EN = 1'b1,
  parameter int ACC_W     = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [W-1:0]     vdc,
  input  logic signed [W-1:0]     ia,
  input  logic signed [W-1:0]     ib,
  input  logic signed [W-1:0]     ic,
  input  logic signed [W-1:0]     bemf_a,
  input  logic signed [W-1:0]     bemf_b,
  input  logic signed [W-1:0]     bemf_c,
  input  logic [5:0]              gates,
  input  logic                    pulse_off,
  input  logic                    sync,
  output logic                    out_valid,
  output logic signed [W-1:0]     va,
  output logic signed [W-1:0]     vb,
  output logic signed [W-1:0]     vc,
  output logic [2:0]              hiz,
  output logic                    shoot_err,
  output logic signed [ACC_W-1:0] idc_sum
);
  localparam int USE_VF  = (VF_PU != 0) ? 1 : 0;
  localparam int USE_RON = (RON_PU != 0) ? 1 : 0;
  localparam int LAT     = 8 + 5 * USE_VF + 5 * USE_RON;
  localparam int DLY     = LAT - 1;
  localparam int DW      = 3 * W + 4;
  localparam int XW      = W + 6;
  localparam int PW      = 2 * W + 1;
  localparam int SW      = W + 2;
  localparam logic signed [W-1:0]  RON_S = W'(RON_PU);
  localparam logic signed [W-1:0]  VF_S  = W'(VF_PU);
  localparam logic signed [XW-1:0] MAXV  = XW'((1 <<< (W-1)) - 1);
  localparam logic signed [XW-1:0] MINV  = -XW'(1 <<< (W-1));

  function automatic logic [W+2:0] leg(input logic t, input logic b,
                                       input logic signed [W-1:0] v_dc,
                                       input logic signed [W-1:0] cur,
                                       input logic signed [W-1:0] emf);
    logic signed [2*W-1:0] prod;
    logic signed [PW-1:0]  rnd;
    logic signed [XW-1:0]  drop, vfx, vx, raw;
    logic hz, er, tc;
    prod = RON_S * cur;
    rnd  = PW'(prod) + PW'(1 <<< (FRAC - 1));
    drop = (USE_RON != 0) ? XW'(rnd >>> FRAC) : '0;
    vfx  = (USE_VF != 0) ? XW'(VF_S) : '0;
    vx   = XW'(v_dc);
    hz = 1'b0; er = 1'b0; tc = 1'b0;
    if (t && b) begin
      er  = 1'b1;
      raw = vfx - drop;
    end else if (t) begin
      tc  = 1'b1;
      raw = vx - vfx - drop;
    end else if (b) begin
      raw = vfx - drop;
    end else if (cur > 0) begin
      raw = -vfx;
    end else if (cur < 0) begin
      tc  = 1'b1;
      raw = vx + vfx;
    end else begin
      hz  = 1'b1;
      raw = XW'(emf);
    end
    if (raw > MAXV)      raw = MAXV;
    else if (raw < MINV) raw = MINV;
    return {tc, hz, er, raw[W-1:0]};
  endfunction

  logic                v_q;
  logic [5:0]          g_q;
  logic signed [W-1:0] vdc_q, ia_q, ib_q, ic_q, ea_q, eb_q, ec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      g_q <= '0;
      vdc_q <= '0; ia_q <= '0; ib_q <= '0; ic_q <= '0;
      ea_q <= '0; eb_q <= '0; ec_q <= '0;
    end else begin
      v_q <= in_valid;
      g_q <= pulse_off ? 6'b0 : gates;
      vdc_q <= vdc; ia_q <= ia; ib_q <= ib; ic_q <= ic;
      ea_q <= bemf_a; eb_q <= bemf_b; ec_q <= bemf_c;
    end
  end

  logic [W+2:0] la, lb, lc;
  assign la = leg(g_q[5], g_q[4], vdc_q, ia_q, ea_q);
  assign lb = leg(g_q[3], g_q[2], vdc_q, ib_q, eb_q);
  assign lc = leg(g_q[1], g_q[0], vdc_q, ic_q, ec_q);

  logic [DW-1:0] stage;
  assign stage = {la[W-1:0], lb[W-1:0], lc[W-1:0],
                  la[W+1], lb[W+1], lc[W+1], la[W] | lb[W] | lc[W]};

  logic [DW-1:0]  pipe_d [DLY-1];
  logic [DLY-2:0] pipe_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_v <= '0;
      for (int k = 0; k < DLY - 1; k++) pipe_d[k] <= '0;
    end else begin
      pipe_v    <= {pipe_v[DLY-3:0], v_q};
      pipe_d[0] <= stage;
      for (int k = 1; k < DLY - 1; k++) pipe_d[k] <= pipe_d[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      {va, vb, vc, hiz, shoot_err} <= '0;
    end else begin
      out_valid <= pipe_v[DLY-2];
      if (pipe_v[DLY-2]) {va, vb, vc, hiz, shoot_err} <= pipe_d[DLY-2];
    end
  end

  generate
    if (DCLINK_EN) begin : g_dclink
      logic signed [SW-1:0]    isum;
      logic signed [ACC_W-1:0] acc;
      logic signed [ACC_W:0]   nxt;
      assign isum = (la[W+2] ? SW'(ia_q) : '0)
                  + (lb[W+2] ? SW'(ib_q) : '0)
                  + (lc[W+2] ? SW'(ic_q) : '0);
      assign nxt  = (ACC_W+1)'(acc) + (ACC_W+1)'(isum);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          acc     <= '0;
          idc_sum <= '0;
        end else if (sync) begin
          idc_sum <= acc;
          acc     <= v_q ? ACC_W'(isum) : '0;
        end else if (v_q) begin
          if (nxt[ACC_W] != nxt[ACC_W-1])
            acc <= nxt[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
          else
            acc <= nxt[ACC_W-1:0];
        end
      end
    end else begin : g_no_dclink
      assign idc_sum = '0;
    end
  endgenerate
endmodule

module inv3ph_model_chk #(
  parameter int W     = 18,
  parameter int ACC_W = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    sync,
  input logic                    out_valid,
  input logic signed [W-1:0]     va,
  input logic signed [W-1:0]     vb,
  input logic signed [W-1:0]     vc,
  input logic [2:0]              hiz,
  input logic                    shoot_err,
  input logic signed [ACC_W-1:0] idc_sum
);
  logic [31:0] n_in, n_out;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      n_in  <= n_in + 32'(in_valid);
      n_out <= n_out + 32'(out_valid);
    end
  end

  assert_no_spurious_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    n_out <= n_in);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(va) && $stable(vb) && $stable(vc) && $stable(hiz) && $stable(shoot_err)));

  assert_short_not_floating_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shoot_err |-> (hiz != 3'b111));

  assert_sum_only_on_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(idc_sum));
endmodule

bind inv3ph_model inv3ph_model_chk #(.W(W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/inv3ph_model_bench.sv
`timescale 1ns/1ps
module inv3ph_model_bench;
  localparam int W = 18, ACC_W = 24, VF = 1638, RON = 3277;
  localparam int LAT = 8 + ((VF != 0) ? 5 : 0) + ((RON != 0) ? 5 : 0);

  logic clk = 0, rst_n = 0, in_valid = 0, pulse_off = 0, sync = 0;
  logic signed [W-1:0] vdc = 0, ia = 0, ib = 0, ic = 0, ea = 0, eb = 0, ec = 0;
  logic [5:0] gates = 0;
  logic out_valid, shoot_err;
  logic signed [W-1:0] va, vb, vc;
  logic [2:0] hiz;
  logic signed [ACC_W-1:0] idc_sum;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  inv3ph_model #(.W(W), .VF_PU(VF), .RON_PU(RON), .DCLINK_EN(1'b1), .ACC_W(ACC_W)) u_inv3ph_model (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vdc(vdc), .ia(ia), .ib(ib), .ic(ic),
    .bemf_a(ea), .bemf_b(eb), .bemf_c(ec), .gates(gates), .pulse_off(pulse_off), .sync(sync),
    .out_valid(out_valid), .va(va), .vb(vb), .vc(vc), .hiz(hiz), .shoot_err(shoot_err),
    .idc_sum(idc_sum));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(longint x);
    if (x > 131071) return 131071;
    if (x < -131072) return -131072;
    return x;
  endfunction

  function automatic longint exp_v(bit t, bit b, longint v_dc, longint cur, longint emf,
                                   output bit hz, output bit er);
    longint drop = (longint'(RON) * cur + 16384) >>> 15;
    hz = 0; er = 0;
    if (t && b) begin er = 1; return sat(VF - drop); end
    if (t) return sat(v_dc - VF - drop);
    if (b) return sat(VF - drop);
    if (cur > 0) return sat(-VF);
    if (cur < 0) return sat(v_dc + VF);
    hz = 1;
    return sat(emf);
  endfunction

  task automatic run_vec(string req, logic [5:0] g, bit off, longint v_dc,
                         longint a, longint b, longint c, longint e1, longint e2, longint e3);
    bit ha, hb, hc, ra, rb, rc;
    longint xa, xb, xc;
    int n = 0;
    logic [5:0] eg = off ? 6'b0 : g;
    xa = exp_v(eg[5], eg[4], v_dc, a, e1, ha, ra);
    xb = exp_v(eg[3], eg[2], v_dc, b, e2, hb, rb);
    xc = exp_v(eg[1], eg[0], v_dc, c, e3, hc, rc);
    @(negedge clk);
    gates = g; pulse_off = off; vdc = W'(v_dc);
    ia = W'(a); ib = W'(b); ic = W'(c); ea = W'(e1); eb = W'(e2); ec = W'(e3);
    in_valid = 1;
    do begin
      @(negedge clk);
      in_valid = 0;
      n++;
    end while (!out_valid && n < 40);
    check({req, " R8 latency"}, n, LAT);
    check({req, " va"}, va, xa);
    check({req, " vb"}, vb, xb);
    check({req, " vc"}, vc, xc);
    check({req, " hiz R5"}, hiz, {ha, hb, hc});
    check({req, " shoot_err R3"}, shoot_err, ra | rb | rc);
  endtask

  task automatic t_reset();
    check("R9 reset out_valid", out_valid, 0);
    check("R9 reset va", va, 0);
    check("R9 reset hiz", hiz, 0);
    check("R10 reset idc_sum", idc_sum, 0);
  endtask

  task automatic t_driven();
    run_vec("R1 R2 mixed", 6'b10_01_10, 0, 26214, 3000, -4000, 100, 0, 0, 0);
    run_vec("R1 R2 swapped", 6'b01_10_01, 0, 16384, -9000, 12000, 0, 500, 500, 500);
  endtask

  task automatic t_shoot();
    run_vec("R3 both on", 6'b11_00_01, 0, 26214, 2000, 5000, -2000, 0, 0, 0);
  endtask

  task automatic t_diodes();
    run_vec("R4 R5 freewheel", 6'b00_00_00, 0, 26214, 1000, -1000, 0, 1, 2, 7000);
    run_vec("R5 all floating", 6'b00_00_00, 0, 26214, 0, 0, 0, -3000, 4000, 9000);
  endtask

  task automatic t_disable();
    run_vec("R6 pulse_off", 6'b11_11_11, 1, 26214, 500, -500, 0, 0, 0, -1234);
  endtask

  task automatic t_saturate();
    run_vec("R7 high clip", 6'b00_01_00, 0, 131071, -20, -131072, 50, 0, 0, 0);
    run_vec("R7 low clip", 6'b10_00_10, 0, -131072, 131071, 0, 60000, 0, 0, 0);
  endtask

  task automatic t_hold();
    longint a0 = va, b0 = vb, c0 = vc, h0 = hiz;
    repeat (6) @(negedge clk);
    check("R9 idle out_valid", out_valid, 0);
    check("R9 hold va", va, a0);
    check("R9 hold vb", vb, b0);
    check("R9 hold vc", vc, c0);
    check("R9 hold hiz", hiz, h0);
  endtask

  task automatic t_dclink();
    longint held;
    @(negedge clk); sync = 1;
    @(negedge clk); sync = 0;
    held = idc_sum;
    gates = 6'b10_01_01; pulse_off = 0; ia = 1000; ib = 300; ic = -200; in_valid = 1;
    @(negedge clk); gates = 6'b00_00_00; ia = 200; ib = -500; ic = 0;
    @(negedge clk); gates = 6'b11_10_00; ia = 700; ib = 250; ic = 0;
    @(negedge clk); in_valid = 0;
    repeat (3) @(negedge clk);
    check("R10 no change without sync", idc_sum, held);
    sync = 1;
    @(negedge clk); sync = 0;
    check("R10 period sum", idc_sum, 750);
    @(negedge clk); sync = 1;
    @(negedge clk); sync = 0;
    check("R10 cleared after sync", idc_sum, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_driven();
    t_shoot();
    t_diodes();
    t_disable();
    t_saturate();
    t_hold();
    t_dclink();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule